// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads bytes out of a one-time-programmable fuse array by driving the array macro's raw control word directly. A caller issues a request that names a starting byte and a byte count. The block turns the request into a range of 32-bit fuse words. For each word it runs a timed arm, strobe and release sequence on the macro. It then hands the requested bytes to the consumer one per handshake on a valid/ready stream.

After the last word the control word drops to a low-power standby pattern. The block then raises a one-cycle completion pulse. With that pulse it reports whether the request asked for bytes beyond the end of the array. The array is only ever read, never programmed, and reading does not alter its contents.

Top module: `fuse_read_seq`

## Requirements
- R1: Out of reset and whenever idle (busy low), `fuseCtrl` equals 32'h0000_0021: power-down at bit 5 and chip-select-bar at bit 0, nothing else. `outValid` and `done` are low.
- R2: A request is taken only in a cycle where `reqValid` is high and `busy` is low. A `reqValid` pulse while busy has no effect on the strobed words, the returned bytes or the flags.
- R3: After a request is taken, `fuseCtrl` equals 32'h0000_028C for exactly SETUP_CYC cycles before the first strobe. This is strobe-select bit 9, sense bit 7, program-enable-bar bit 3 and load bit 2, with chip-select-bar low and address 0.
- R4: Each word is strobed with `fuseCtrl` = 32'h28E | (word << 16), the address being a 10-bit field at bit 16, for exactly STROBE_CYC cycles. It is then released with `fuseCtrl` = 32'h28C | (word << 16) for RELEASE_CYC cycles before its first byte is offered. The address does not change while the strobe is high.
- R5: The strobed words run in ascending order from offset/4 up to, but not including, min(ceil((offset+length)/4), 32). Each word is strobed once. A request that maps to no word strobes nothing.
- R6: The returned bytes are array bytes offset through min(offset+length,128)-1, in ascending order. Byte k of the array is bits [8*(k%4)+7 : 8*(k%4)] of word k/4, so lanes are little-endian and a read may start at any lane.
- R7: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` holds. No strobe is issued while a byte is waiting.
- R8: When the last word is finished, or at the end of setup if there is no word, `fuseCtrl` returns to 32'h21. `done` is high for exactly one cycle per request. `busy` is low in the following cycle.
- R9: `overflow` is high only together with `done`, and only when offset+length exceeds 128.
- R10: Program-enable-bar (bit 3) is never low while chip-select-bar (bit 0) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, sampled when idle |
| reqOffset | input | 8 | Starting byte of the read |
| reqLength | input | 9 | Number of bytes requested |
| busy | output | 1 | High from request acceptance through the done cycle |
| outValid | output | 1 | Byte available on outData |
| outData | output | 8 | Returned byte |
| outReady | input | 1 | Consumer accepts the byte |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Request ran past the array, valid with done |
| fuseCtrl | output | 32 | Control word to the fuse macro |
| fuseDout | input | 32 | Data word from the fuse macro |

## Verification
A request taken at a clock edge shows the setup pattern from that edge on. The first strobe follows SETUP_CYC edges later, and each strobe lasts STROBE_CYC edges. The first byte of a word is offered RELEASE_CYC edges after its strobe falls. `done` comes one cycle after the last byte handshake is seen to exhaust the word, and `busy` drops one edge after `done`. The bench drives inputs and samples every output on the falling edge. It counts run lengths of each control pattern on those samples instead of waiting fixed delays, so each interval is compared with its exact parameter value. Collected bytes, word addresses and the overflow value seen with `done` are compared after `done` against values computed from the offset and length.

// File: rtl/fuse_read_pkg.sv
package fuse_read_pkg;
  // control word bit positions expected by the fuse macro
  localparam int unsigned CB_CSB    = 0;
  localparam int unsigned CB_STROBE = 1;
  localparam int unsigned CB_LOAD   = 2;
  localparam int unsigned CB_PGENB  = 3;
  localparam int unsigned CB_PD     = 5;
  localparam int unsigned CB_SENSE  = 7;
  localparam int unsigned CB_SSEL   = 9;
  localparam int unsigned CB_ADDR   = 16;
  localparam int unsigned ADDR_BITS = 10;
  localparam int unsigned BYTES_PER_WORD = 4;

  typedef enum logic [1:0] {
    MAC_STANDBY,
    MAC_SETUP,
    MAC_STROBE,
    MAC_HOLD
  } macMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     take;
    logic     sample;
    logic     nextWord;
    logic     pop;
    macMode_e mode;
  } seqStrb_t;
endpackage

// File: rtl/fuse_read_dp.sv
module fuse_read_dp
  import fuse_read_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 32,
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned LEN_W     = 9,
  parameter int unsigned WIDX_W    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrb_t         strb,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [LEN_W-1:0] reqLength,
  input  logic [31:0]      fuseDout,
  output logic [31:0]      fuseCtrl,
  output logic [7:0]       outData,
  output logic             haveByte,
  output logic             lastWord,
  output logic             noWords,
  output logic             ovfPending
);
  localparam int unsigned NUM_BYTES = NUM_WORDS * BYTES_PER_WORD;
  localparam int unsigned SUM_W     = LEN_W + 1;

  logic [SUM_W-1:0]  reqSum;
  logic [SUM_W-1:0]  sumCap;
  logic [SUM_W-1:0]  endRaw;
  logic [SUM_W-1:0]  endCap;

  logic [WIDX_W-1:0] curWord;
  logic [WIDX_W-1:0] endWord;
  logic [OFF_W-1:0]  bytePtr;
  logic [OFF_W-1:0]  byteEnd;
  logic              ovfReg;
  logic [31:0]       wordBuf;
  logic [7:0]        lanes [BYTES_PER_WORD];
  logic [31:0]       addrField;

  // request range arithmetic
  always_comb begin
    reqSum = SUM_W'(reqOffset) + SUM_W'(reqLength);
    sumCap = (reqSum > SUM_W'(NUM_BYTES)) ? SUM_W'(NUM_BYTES) : reqSum;
    endRaw = (reqSum + SUM_W'(BYTES_PER_WORD - 1)) >> 2;
    endCap = (endRaw > SUM_W'(NUM_WORDS)) ? SUM_W'(NUM_WORDS) : endRaw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWord <= '0;
      endWord <= '0;
      bytePtr <= '0;
      byteEnd <= '0;
      ovfReg  <= 1'b0;
      wordBuf <= '0;
    end else begin
      if (strb.take) begin
        curWord <= reqOffset[OFF_W-1:2];
        endWord <= WIDX_W'(endCap);
        bytePtr <= reqOffset;
        byteEnd <= OFF_W'(sumCap);
        ovfReg  <= (reqSum > SUM_W'(NUM_BYTES));
      end
      if (strb.sample)   wordBuf <= fuseDout;
      if (strb.nextWord) curWord <= curWord + 1'b1;
      if (strb.pop)      bytePtr <= bytePtr + 1'b1;
    end
  end

  // little-endian lane split
  for (genvar g = 0; g < BYTES_PER_WORD; g++) begin : gLane
    assign lanes[g] = wordBuf[8*g +: 8];
  end

  assign outData    = lanes[bytePtr[1:0]];
  assign haveByte   = (bytePtr < byteEnd) && (bytePtr[OFF_W-1:2] == curWord);
  assign lastWord   = ({1'b0, curWord} + 1'b1) >= {1'b0, endWord};
  assign noWords    = curWord >= endWord;
  assign ovfPending = ovfReg;

  assign addrField = 32'(curWord) << CB_ADDR;

  always_comb begin
    unique case (strb.mode)
      MAC_SETUP:  fuseCtrl = (32'd1 << CB_LOAD) | (32'd1 << CB_PGENB)
                           | (32'd1 << CB_SSEL) | (32'd1 << CB_SENSE);
      MAC_STROBE: fuseCtrl = (32'd1 << CB_LOAD) | (32'd1 << CB_PGENB)
                           | (32'd1 << CB_SSEL) | (32'd1 << CB_SENSE)
                           | (32'd1 << CB_STROBE) | addrField;
      MAC_HOLD:   fuseCtrl = (32'd1 << CB_LOAD) | (32'd1 << CB_PGENB)
                           | (32'd1 << CB_SSEL) | (32'd1 << CB_SENSE)
                           | addrField;
      default:    fuseCtrl = (32'd1 << CB_PD) | (32'd1 << CB_CSB);
    endcase
  end
endmodule

// File: rtl/fuse_read_ctrl.sv
module fuse_read_ctrl
  import fuse_read_pkg::*;
#(
  parameter int unsigned SETUP_CYC   = 250,
  parameter int unsigned STROBE_CYC  = 250,
  parameter int unsigned RELEASE_CYC = 250
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     outReady,
  input  logic     haveByte,
  input  logic     lastWord,
  input  logic     noWords,
  output seqStrb_t strb,
  output logic     busy,
  output logic     outValid,
  output logic     done
);
  localparam int unsigned MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int unsigned MAX_C = (MAX_A > RELEASE_CYC) ? MAX_A : RELEASE_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_RELEASE, ST_DRAIN, ST_STBY
  } seqState_e;

  seqState_e        state, nextState;
  logic [CNT_W-1:0] cnt;
  logic             timed;

  always_comb begin
    strb      = '0;
    strb.mode = MAC_STANDBY;
    nextState = state;
    outValid  = 1'b0;
    done      = 1'b0;
    timed     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.take = 1'b1;
          nextState = ST_SETUP;
        end
      end
      ST_SETUP: begin
        strb.mode = MAC_SETUP;
        timed     = 1'b1;
        if (cnt == CNT_W'(SETUP_CYC - 1))
          nextState = noWords ? ST_STBY : ST_STROBE;
      end
      ST_STROBE: begin
        strb.mode = MAC_STROBE;
        timed     = 1'b1;
        if (cnt == CNT_W'(STROBE_CYC - 1)) begin
          strb.sample = 1'b1;
          nextState   = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        strb.mode = MAC_HOLD;
        timed     = 1'b1;
        if (cnt == CNT_W'(RELEASE_CYC - 1)) nextState = ST_DRAIN;
      end
      ST_DRAIN: begin
        strb.mode = MAC_HOLD;
        if (haveByte) begin
          outValid = 1'b1;
          strb.pop = outReady;
        end else if (lastWord) begin
          nextState = ST_STBY;
        end else begin
          strb.nextWord = 1'b1;
          nextState     = ST_STROBE;
        end
      end
      default: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (nextState != state || !timed) cnt <= '0;
      else                              cnt <= cnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
  import fuse_read_pkg::*;
#(
  parameter int unsigned NUM_WORDS   = 32,
  parameter int unsigned SETUP_CYC   = 250,
  parameter int unsigned STROBE_CYC  = 250,
  parameter int unsigned RELEASE_CYC = 250,
  localparam int unsigned OFF_W  = $clog2(NUM_WORDS * BYTES_PER_WORD) + 1,
  localparam int unsigned LEN_W  = OFF_W + 1,
  localparam int unsigned WIDX_W = OFF_W - 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [LEN_W-1:0] reqLength,
  output logic             busy,
  output logic             outValid,
  output logic [7:0]       outData,
  input  logic             outReady,
  output logic             done,
  output logic             overflow,
  output logic [31:0]      fuseCtrl,
  input  logic [31:0]      fuseDout
);
  seqStrb_t strb;
  logic     haveByte, lastWord, noWords, ovfPending;

  fuse_read_ctrl #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .RELEASE_CYC(RELEASE_CYC)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .outReady(outReady),
    .haveByte(haveByte),
    .lastWord(lastWord),
    .noWords (noWords),
    .strb    (strb),
    .busy    (busy),
    .outValid(outValid),
    .done    (done)
  );

  fuse_read_dp #(
    .NUM_WORDS(NUM_WORDS),
    .OFF_W    (OFF_W),
    .LEN_W    (LEN_W),
    .WIDX_W   (WIDX_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqOffset (reqOffset),
    .reqLength (reqLength),
    .fuseDout  (fuseDout),
    .fuseCtrl  (fuseCtrl),
    .outData   (outData),
    .haveByte  (haveByte),
    .lastWord  (lastWord),
    .noWords   (noWords),
    .ovfPending(ovfPending)
  );

  assign overflow = done & ovfPending;
endmodule

// File: rtl/fuse_read_chk.sv
module fuse_read_chk #(
  parameter int unsigned STROBE_CYC = 250
) (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        outValid,
  input logic [7:0]  outData,
  input logic        outReady,
  input logic        done,
  input logic        overflow,
  input logic [31:0] fuseCtrl
);
  logic [31:0] strobeRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeRun <= '0;
    else       strobeRun <= fuseCtrl[1] ? strobeRun + 1 : 32'd0;
  end

  a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (fuseCtrl == 32'h0000_0021 && !outValid && !done));

  a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rstN)
    (!fuseCtrl[1] && strobeRun != 0) |-> (strobeRun == STROBE_CYC));

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (fuseCtrl[1] && $past(fuseCtrl[1])) |-> (fuseCtrl[25:16] == $past(fuseCtrl[25:16])));

  a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  a_r7_no_strobe_waiting: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !fuseCtrl[1]);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  a_r9_ovf_with_done: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> done);

  a_r10_no_program: assert property (@(posedge clk) disable iff (!rstN)
    (fuseCtrl[0] || fuseCtrl[3]));
endmodule

bind fuse_read_seq fuse_read_chk #(.STROBE_CYC(STROBE_CYC)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .outValid(outValid),
  .outData (outData),
  .outReady(outReady),
  .done    (done),
  .overflow(overflow),
  .fuseCtrl(fuseCtrl)
);

// File: tb/fuse_read_seq_tb_top.sv
`timescale 1ns/1ps
module fuse_read_seq_tb_top;
  localparam int SETUP_CYC   = 3;
  localparam int STROBE_CYC  = 2;
  localparam int RELEASE_CYC = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqOffset = '0;
  logic [8:0]  reqLength = '0;
  logic        busy, outValid, done, overflow;
  logic [7:0]  outData;
  logic        outReady = 1'b0;
  logic [31:0] fuseCtrl, fuseDout;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fuse_read_seq #(
    .NUM_WORDS(32), .SETUP_CYC(SETUP_CYC),
    .STROBE_CYC(STROBE_CYC), .RELEASE_CYC(RELEASE_CYC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOffset(reqOffset),
    .reqLength(reqLength), .busy(busy), .outValid(outValid), .outData(outData),
    .outReady(outReady), .done(done), .overflow(overflow),
    .fuseCtrl(fuseCtrl), .fuseDout(fuseDout)
  );

  function automatic logic [7:0] byteVal(input int k);
    return 8'(((k * 29) + 7) ^ 8'h5A);
  endfunction

  function automatic logic [31:0] fuseWord(input int w);
    return {byteVal(4*w+3), byteVal(4*w+2), byteVal(4*w+1), byteVal(4*w)};
  endfunction

  // behavioural fuse macro
  always_comb begin
    if (!fuseCtrl[0] && fuseCtrl[1]) fuseDout = fuseWord(int'(fuseCtrl[25:16]));
    else                             fuseDout = 32'hA5A5_0F0F;
  end

  // monitor state
  int readyMode = 0;
  int gotN, nW, strobeBad, relBad, setupCnt, setupValBad, stallBad, doneCount, progBad;
  logic [7:0] gotBytes [0:255];
  int gotW [0:63];
  bit ovfAtDone, doneSeen, prevStrobe, seenStrobe, relActive, prevStall;
  int sRun, relCnt, lastAddr;
  logic [7:0] prevData;

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      case (readyMode)
        1:       outReady = (cycles % 3) != 0;
        2:       outReady = (cycles % 4) < 2;
        default: outReady = 1'b1;
      endcase
      if (outValid && outReady && gotN < 256) begin
        gotBytes[gotN] = outData;
        gotN++;
      end
      if (prevStall && (!outValid || outData != prevData)) stallBad++;
      prevStall = outValid && !outReady;
      prevData  = outData;
      if (!fuseCtrl[0] && !fuseCtrl[3]) progBad++;
      if (busy && fuseCtrl[2] && !seenStrobe && !fuseCtrl[1]) begin
        setupCnt++;
        if (fuseCtrl != 32'h28C) setupValBad++;
      end
      if (relActive) begin
        if (outValid) begin
          if (relCnt != RELEASE_CYC) relBad++;
          relActive = 0;
        end else if (fuseCtrl[1] || !fuseCtrl[2]) begin
          relActive = 0;
        end else begin
          relCnt++;
          if (fuseCtrl != (32'h28C | (32'(lastAddr) << 16))) relBad++;
        end
      end
      if (fuseCtrl[1]) begin
        if (!prevStrobe && nW < 64) begin
          lastAddr = int'(fuseCtrl[25:16]);
          gotW[nW] = lastAddr;
          nW++;
        end
        seenStrobe = 1;
        sRun++;
        if (fuseCtrl != (32'h28E | (32'(lastAddr) << 16))) strobeBad++;
      end else if (prevStrobe) begin
        if (sRun != STROBE_CYC) strobeBad++;
        sRun = 0;
        relActive = 1;
        relCnt = 1;
        if (fuseCtrl != (32'h28C | (32'(lastAddr) << 16))) relBad++;
      end
      prevStrobe = fuseCtrl[1];
      if (done) begin
        doneSeen = 1;
        doneCount++;
        ovfAtDone = overflow;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearMon(input int mode);
    @(posedge clk); #1;
    readyMode = mode;
    gotN = 0; nW = 0; strobeBad = 0; relBad = 0; setupCnt = 0; setupValBad = 0;
    stallBad = 0; doneCount = 0; ovfAtDone = 0; doneSeen = 0; prevStrobe = 0;
    seenStrobe = 0; relActive = 0; prevStall = 0; sRun = 0; relCnt = 0;
  endtask

  task automatic runRead(input int off, input int len, input int mode,
                         input bit intrude, input string tag);
    int effEnd, nb, sw, ew, nw, guard, firstBad, wordBad;
    clearMon(mode);
    @(negedge clk);
    reqValid = 1'b1; reqOffset = 8'(off); reqLength = 9'(len);
    @(negedge clk);
    reqValid = 1'b0;
    if (intrude) begin
      @(negedge clk);
      reqValid = 1'b1; reqOffset = 8'd64; reqLength = 9'd4;
      @(negedge clk);
      reqValid = 1'b0;
    end
    guard = 0;
    while (!doneSeen && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    // R8: back to standby, done once
    chk(!busy && fuseCtrl == 32'h21, "R8", {tag, " standby ctrl"}, int'(fuseCtrl), 32'h21);
    chk(doneCount == 1, "R8", {tag, " done pulses"}, doneCount, 1);
    effEnd = (off + len > 128) ? 128 : off + len;
    nb = (off < effEnd) ? effEnd - off : 0;
    sw = off / 4;
    ew = (off + len + 3) / 4;
    if (ew > 32) ew = 32;
    nw = (ew > sw) ? ew - sw : 0;
    chk(gotN == nb, "R6", {tag, " byte count"}, gotN, nb);
    firstBad = -1;
    for (int i = 0; i < nb && i < gotN; i++)
      if (gotBytes[i] !== byteVal(off + i) && firstBad < 0) firstBad = i;
    chk(firstBad < 0, "R6", {tag, " byte value"},
        (firstBad < 0) ? 0 : int'(gotBytes[firstBad]),
        (firstBad < 0) ? 0 : int'(byteVal(off + firstBad)));
    chk(nW == nw, "R5", {tag, " word count"}, nW, nw);
    wordBad = -1;
    for (int i = 0; i < nw && i < nW; i++)
      if (gotW[i] != sw + i && wordBad < 0) wordBad = i;
    chk(wordBad < 0, "R5", {tag, " word order"},
        (wordBad < 0) ? 0 : gotW[wordBad], (wordBad < 0) ? 0 : sw + wordBad);
    chk(setupCnt == SETUP_CYC && setupValBad == 0, "R3", {tag, " setup cycles"},
        setupCnt, SETUP_CYC);
    chk(strobeBad == 0 && relBad == 0, "R4", {tag, " strobe/release timing"},
        strobeBad + relBad, 0);
    chk(stallBad == 0, "R7", {tag, " held under backpressure"}, stallBad, 0);
    chk(ovfAtDone == (off + len > 128), "R9", {tag, " overflow flag"},
        int'(ovfAtDone), int'(off + len > 128));
  endtask

  // watchdog
  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    progBad = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(fuseCtrl == 32'h21 && !busy && !outValid && !done, "R1", "reset state",
        int'(fuseCtrl), 32'h21);
    rstN = 1'b1;
    @(negedge clk);
    chk(fuseCtrl == 32'h21 && !busy, "R1", "idle after reset", int'(fuseCtrl), 32'h21);

    runRead(0, 8, 0, 0, "aligned");
    runRead(5, 6, 0, 0, "unaligned");
    runRead(3, 9, 1, 0, "backpressure R7");
    runRead(0, 128, 2, 0, "whole array");
    runRead(120, 20, 0, 0, "past end R9");
    runRead(130, 4, 0, 0, "start beyond array");
    runRead(5, 0, 0, 0, "zero length");
    runRead(0, 4, 0, 1, "busy request R2");
    runRead(127, 1, 1, 0, "last byte");

    chk(progBad == 0, "R10", "program-enable-bar stays high", progBad, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule